// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block chooses the instruction fetch address of a small microcontroller core whose instructions are 14 bits wide. It keeps a 13-bit program counter, a 5-bit page latch that supplies the upper address bits on computed branches, and an eight-entry return-address stack. Each clock cycle it takes at most one sequencing request: an interrupt entry, a call, a jump, a return, a write of the low address byte, or a plain step. When several arrive together, a fixed priority picks one.

The stack is a ring. Software cannot see its pointer, and no instruction pushes or pops it directly. A call or an interrupt entry stores the address of the next instruction. A return takes back the most recent entry. Once eight entries are full, a further push replaces the oldest entry without notice. A return on an empty stack also wraps the pointer, without raising any flag. The page latch is written only through its own write port, and stack activity never changes it.

Top module: `pcseq_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fetch_addr` is 0x0000, `latch_out` is 0x00, and every stack entry holds 0x0000.
- R2: With `step_en` as the only request, `fetch_addr` rises by one on the next clock edge and wraps from 0x1FFF to 0x0000. With no request asserted, `fetch_addr` holds its value.
- R3: `irq_take` loads `fetch_addr` with 0x0004 and pushes the old `fetch_addr`+1 onto the stack.
- R4: `jump_en` loads `fetch_addr` with {latch bits [4:3], `tgt_addr`[10:0]}, using the latch value from before that edge.
- R5: `call_en` loads the same target as R4 and pushes the old `fetch_addr`+1.
- R6: `ret_en` loads `fetch_addr` with the most recently pushed entry that has not yet been popped (last in, first out).
- R7: The stack holds 8 entries in a ring. After nine pushes in a row, the following pops return the 9th, 8th, ... 2nd pushed values, and a ninth pop returns the 9th value again.
- R8: A pop on an empty stack wraps the pointer and returns the stored entry. Directly after reset this entry is 0x0000.
- R9: `pcl_wr_en` loads `fetch_addr` with {latch[4:0], `pcl_wr_data`[7:0]}, using the latch value from before that edge.
- R10: `latch_wr_en` loads `latch_out` from `latch_wr_data` on the next edge. Pushes and pops never change the latch. A latch write in the same cycle as any other request takes effect alongside it.
- R11: The priority, from highest to lowest, is `irq_take`, `call_en`, `jump_en`, `ret_en`, `pcl_wr_en`, `step_en`. A lower request that loses in a cycle has no effect, so a losing call pushes nothing and a losing return pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance to the next sequential address |
| irq_take | input | 1 | Interrupt accepted: push and go to the vector |
| call_en | input | 1 | Subroutine call to `tgt_addr` |
| jump_en | input | 1 | Unconditional jump to `tgt_addr` |
| ret_en | input | 1 | Return: pop the stack into the PC |
| tgt_addr | input | 11 | Branch target field from the instruction |
| pcl_wr_en | input | 1 | Write of the low PC byte register |
| pcl_wr_data | input | 8 | Data for the low PC byte write |
| latch_wr_en | input | 1 | Write of the page latch |
| latch_wr_data | input | 5 | Data for the page latch write |
| fetch_addr | output | 13 | Current program counter / fetch address |
| latch_out | output | 5 | Current page latch value |

## Verification
The stimulus starts with plain steps, including one across the 0x1FFF wrap. It then covers jumps and low-byte writes under different latch values, which shows whether the two page-bit sources are kept apart and whether each uses the latch value from before a same-cycle latch write. Requests are also stacked in the same cycle (interrupt with call and return, call with jump, jump with return, byte write with step). A later return then shows whether a losing request still moved the stack. After a fresh reset, two pops on the empty stack are followed by nine calls and ten returns. This shows the ring order and the overwrite of the oldest entry, which a stack that saturated or clamped its pointer would get wrong.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   // Source of the next program counter value, one per request class.
   typedef enum logic [2:0] {
      SEL_HOLD = 3'd0,
      SEL_STEP = 3'd1,
      SEL_BYTE = 3'd2,
      SEL_POP  = 3'd3,
      SEL_JUMP = 3'd4,
      SEL_CALL = 3'd5,
      SEL_IRQ  = 3'd6
   } pc_sel_e;

endpackage

// File: rtl/pcseq_select.sv
module pcseq_select
   import pcseq_pkg::*;
(
   input  logic    step_en,
   input  logic    irq_take,
   input  logic    call_en,
   input  logic    jump_en,
   input  logic    ret_en,
   input  logic    byte_wr,
   output pc_sel_e sel_o,
   output logic    push_o,
   output logic    pop_o
);

   // Fixed priority: interrupt, call, jump, return, byte write, step.
   always_comb begin
      sel_o  = SEL_HOLD;
      push_o = 1'b0;
      pop_o  = 1'b0;
      if (irq_take) begin
         sel_o  = SEL_IRQ;
         push_o = 1'b1;
      end else if (call_en) begin
         sel_o  = SEL_CALL;
         push_o = 1'b1;
      end else if (jump_en) begin
         sel_o  = SEL_JUMP;
      end else if (ret_en) begin
         sel_o  = SEL_POP;
         pop_o  = 1'b1;
      end else if (byte_wr) begin
         sel_o  = SEL_BYTE;
      end else if (step_en) begin
         sel_o  = SEL_STEP;
      end
   end

endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
   parameter int AW    = 13,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   // Elaboration checks: the ring pointer relies on modulo-2^n wrap.
   if (DEPTH < 2) begin : g_bad_depth_small
      $error("pcseq_retstack: DEPTH must be at least 2");
   end
   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth_pow2
      $error("pcseq_retstack: DEPTH must be a power of two");
   end

   logic [PTR_W-1:0] sp_q;
   logic [AW-1:0]    slot_w [DEPTH];

   // One register per ring slot; sp_q points at the next slot to fill.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [AW-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (push && (sp_q == PTR_W'(g))) begin
            ent_q <= push_data;
         end
      end
      assign slot_w[g] = ent_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (push) begin
         sp_q <= sp_q + PTR_W'(1);
      end else if (pop) begin
         sp_q <= sp_q - PTR_W'(1);
      end
   end

   assign top_data = slot_w[sp_q - PTR_W'(1)];

   // R7: a push advances the ring pointer by one, modulo the depth.
   assert_ptr_push_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      push |=> sp_q == $past(sp_q) + PTR_W'(1));

   // R8: a pop steps the pointer back and wraps below slot zero.
   assert_ptr_pop_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> sp_q == $past(sp_q) - PTR_W'(1));

   // R6: the value just pushed is what a pop in the next cycle would return.
   assert_push_top_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_data == $past(push_data));

endmodule

// File: rtl/pcseq_nextpc.sv
module pcseq_nextpc
   import pcseq_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int LO_W    = 8,
   parameter int TGT_W   = 11,
   parameter int IRQ_VEC = 4
) (
   input  pc_sel_e              sel,
   input  logic [PC_W-1:0]      pc_q,
   input  logic [PC_W-LO_W-1:0] latch_q,
   input  logic [TGT_W-1:0]     tgt,
   input  logic [LO_W-1:0]      byte_data,
   input  logic [PC_W-1:0]      pop_data,
   output logic [PC_W-1:0]      pc_next,
   output logic [PC_W-1:0]      ret_addr
);

   localparam int LATCH_W = PC_W - LO_W;
   localparam int PAGE_W  = PC_W - TGT_W;

   if (PAGE_W < 1 || PAGE_W > LATCH_W) begin : g_bad_page
      $error("pcseq_nextpc: page bits must fit in the latch");
   end

   logic [PC_W-1:0] branch_addr;
   logic [PC_W-1:0] byte_addr;

   // Branch page comes from the top latch bits; byte writes use the whole latch.
   assign branch_addr = {latch_q[LATCH_W-1 -: PAGE_W], tgt};
   assign byte_addr   = {latch_q, byte_data};
   assign ret_addr    = pc_q + PC_W'(1);

   always_comb begin
      unique case (sel)
         SEL_IRQ:  pc_next = PC_W'(IRQ_VEC);
         SEL_CALL: pc_next = branch_addr;
         SEL_JUMP: pc_next = branch_addr;
         SEL_POP:  pc_next = pop_data;
         SEL_BYTE: pc_next = byte_addr;
         SEL_STEP: pc_next = ret_addr;
         default:  pc_next = pc_q;
      endcase
   end

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
   import pcseq_pkg::*;
#(
   parameter int PC_W      = 13,
   parameter int LO_W      = 8,
   parameter int TGT_W     = 11,
   parameter int DEPTH     = 8,
   parameter int RESET_VEC = 0,
   parameter int IRQ_VEC   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_en,
   input  logic                 irq_take,
   input  logic                 call_en,
   input  logic                 jump_en,
   input  logic                 ret_en,
   input  logic [TGT_W-1:0]     tgt_addr,
   input  logic                 pcl_wr_en,
   input  logic [LO_W-1:0]      pcl_wr_data,
   input  logic                 latch_wr_en,
   input  logic [PC_W-LO_W-1:0] latch_wr_data,
   output logic [PC_W-1:0]      fetch_addr,
   output logic [PC_W-LO_W-1:0] latch_out
);

   localparam int LATCH_W = PC_W - LO_W;
   localparam int PAGE_W  = PC_W - TGT_W;

   if (LO_W < 1 || LO_W >= PC_W) begin : g_bad_lo
      $error("pcseq_unit: LO_W must be below PC_W");
   end
   if (IRQ_VEC >= (1 << PC_W) || RESET_VEC >= (1 << PC_W)) begin : g_bad_vec
      $error("pcseq_unit: vectors must fit the program counter");
   end

   pc_sel_e           sel;
   logic              push;
   logic              pop;
   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_next;
   logic [PC_W-1:0]   ret_addr;
   logic [PC_W-1:0]   top_data;
   logic [LATCH_W-1:0] latch_q;

   pcseq_select u_select (
      .step_en  (step_en),
      .irq_take (irq_take),
      .call_en  (call_en),
      .jump_en  (jump_en),
      .ret_en   (ret_en),
      .byte_wr  (pcl_wr_en),
      .sel_o    (sel),
      .push_o   (push),
      .pop_o    (pop)
   );

   pcseq_nextpc #(
      .PC_W    (PC_W),
      .LO_W    (LO_W),
      .TGT_W   (TGT_W),
      .IRQ_VEC (IRQ_VEC)
   ) u_nextpc (
      .sel       (sel),
      .pc_q      (pc_q),
      .latch_q   (latch_q),
      .tgt       (tgt_addr),
      .byte_data (pcl_wr_data),
      .pop_data  (top_data),
      .pc_next   (pc_next),
      .ret_addr  (ret_addr)
   );

   pcseq_retstack #(
      .AW    (PC_W),
      .DEPTH (DEPTH)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (ret_addr),
      .top_data  (top_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= PC_W'(RESET_VEC);
      end else begin
         pc_q <= pc_next;
      end
   end

   // Page latch: written only through its own port, independent of sequencing.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (latch_wr_en) begin
         latch_q <= latch_wr_data;
      end
   end

   assign fetch_addr = pc_q;
   assign latch_out  = latch_q;

   // R3: an accepted interrupt lands on the vector.
   assert_irq_vector_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> fetch_addr == PC_W'(IRQ_VEC));

   // R5: a winning call lands on {old page bits, target}.
   assert_call_dest_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (call_en && !irq_take) |=>
         fetch_addr == {$past(latch_q[LATCH_W-1 -: PAGE_W]), $past(tgt_addr)});

   // R2: a lone step adds one to the fetch address.
   assert_step_inc_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !irq_take && !call_en && !jump_en && !ret_en && !pcl_wr_en)
         |=> fetch_addr == $past(fetch_addr) + PC_W'(1));

   // R10: without a latch write the latch holds, whatever the stack does.
   assert_latch_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !latch_wr_en |=> $stable(latch_out));

   // R11: an interrupt suppresses the pop of a simultaneous return.
   assert_irq_no_pop_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> top_data == $past(ret_addr));

endmodule

// File: tb/pcseq_unit_tb.sv
module pcseq_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0, irq_take = 1'b0, call_en = 1'b0;
   logic        jump_en = 1'b0, ret_en = 1'b0, pcl_wr_en = 1'b0, latch_wr_en = 1'b0;
   logic [10:0] tgt_addr = '0;
   logic [7:0]  pcl_wr_data = '0;
   logic [4:0]  latch_wr_data = '0;
   logic [12:0] fetch_addr;
   logic [4:0]  latch_out;

   int checks = 0;
   int errors = 0;

   // Scoreboard queues, one item per driven cycle.
   logic [12:0] q_pc [$];
   logic [4:0]  q_lt [$];
   string       q_req [$];

   // Reference state derived from the requirements.
   logic [12:0] m_pc;
   logic [4:0]  m_lat;
   logic [12:0] m_stk [8];
   int          m_sp;

   always #5 clk = ~clk;

   pcseq_unit dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .step_en       (step_en),
      .irq_take      (irq_take),
      .call_en       (call_en),
      .jump_en       (jump_en),
      .ret_en        (ret_en),
      .tgt_addr      (tgt_addr),
      .pcl_wr_en     (pcl_wr_en),
      .pcl_wr_data   (pcl_wr_data),
      .latch_wr_en   (latch_wr_en),
      .latch_wr_data (latch_wr_data),
      .fetch_addr    (fetch_addr),
      .latch_out     (latch_out)
   );

   task automatic model_reset();
      m_pc = '0;
      m_lat = '0;
      m_sp = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
   endtask

   task automatic model_push(input logic [12:0] v);
      m_stk[m_sp] = v;
      m_sp = (m_sp + 1) % 8;
   endtask

   // Driver: apply one cycle of requests and queue the expected result.
   task automatic go(input bit irq, input bit call, input bit jmp, input bit ret,
                     input bit pw, input logic [7:0] pd, input bit lw,
                     input logic [4:0] ld, input logic [10:0] tg, input bit adv,
                     input string req);
      logic [12:0] nxt;
      @(negedge clk);
      irq_take = irq; call_en = call; jump_en = jmp; ret_en = ret;
      pcl_wr_en = pw; pcl_wr_data = pd; latch_wr_en = lw; latch_wr_data = ld;
      tgt_addr = tg; step_en = adv;
      nxt = m_pc;
      if (irq) begin
         model_push(m_pc + 13'd1);
         nxt = 13'h0004;
      end else if (call) begin
         model_push(m_pc + 13'd1);
         nxt = {m_lat[4:3], tg};
      end else if (jmp) begin
         nxt = {m_lat[4:3], tg};
      end else if (ret) begin
         m_sp = (m_sp + 7) % 8;
         nxt = m_stk[m_sp];
      end else if (pw) begin
         nxt = {m_lat, pd};
      end else if (adv) begin
         nxt = m_pc + 13'd1;
      end
      if (lw) m_lat = ld;
      m_pc = nxt;
      q_pc.push_back(m_pc);
      q_lt.push_back(m_lat);
      q_req.push_back(req);
   endtask

   task automatic idle_inputs();
      irq_take = 0; call_en = 0; jump_en = 0; ret_en = 0; pcl_wr_en = 0;
      latch_wr_en = 0; step_en = 0; tgt_addr = '0; pcl_wr_data = '0; latch_wr_data = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset state seen at the ports while reset is held.
      checks++;
      if (fetch_addr !== 13'h0000 || latch_out !== 5'h00) begin
         errors++;
         $display("FAIL R1 actual pc=%h latch=%h expected pc=0000 latch=00", fetch_addr, latch_out);
      end
      rst_n = 1'b1;
      model_reset();
   endtask

   // Monitor: compare each queued expectation just after the edge it belongs to.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_pc.size() > 0) begin
            logic [12:0] ep;
            logic [4:0]  el;
            string       rq;
            ep = q_pc.pop_front();
            el = q_lt.pop_front();
            rq = q_req.pop_front();
            checks++;
            if (fetch_addr !== ep || latch_out !== el) begin
               errors++;
               $display("FAIL %s actual pc=%h latch=%h expected pc=%h latch=%h",
                        rq, fetch_addr, latch_out, ep, el);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      do_reset();
      // R1: first cycle after reset, nothing requested.
      go(0,0,0,0, 0,8'h00, 0,5'h00, 11'h000, 0, "R1");
      // R2: plain stepping, then hold with no request.
      for (int i = 0; i < 3; i++) go(0,0,0,0, 0,8'h00, 0,5'h00, 11'h000, 1, "R2");
      go(0,0,0,0, 0,8'h00, 0,5'h00, 11'h000, 0, "R2");
      // R5 and R10: call while the latch is written; the call uses the old page.
      go(0,1,0,0, 0,8'h00, 1,5'h1F, 11'h123, 0, "R5_R10");
      go(0,0,0,0, 0,8'h00, 0,5'h00, 11'h000, 1, "R2");
      // R6: return to the instruction after the call; latch untouched (R10).
      go(0,0,0,1, 0,8'h00, 0,5'h00, 11'h000, 0, "R6_R10");
      // R4: jump with page bits 11 reaches the top address.
      go(0,0,1,0, 0,8'h00, 0,5'h00, 11'h7FF, 0, "R4");
      // R2: step across the top wraps to zero.
      go(0,0,0,0, 0,8'h00, 0,5'h00, 11'h000, 1, "R2");
      // R9: byte write uses the latch from before the concurrent latch write.
      go(0,0,0,0, 1,8'hAB, 1,5'h02, 11'h000, 0, "R9");
      go(0,0,0,0, 1,8'h10, 0,5'h00, 11'h000, 0, "R9");
      // R4: latch bits [4:3] are 00 now, low latch bits ignored for jumps.
      go(0,0,1,0, 0,8'h00, 0,5'h00, 11'h055, 0, "R4");
      // R3 and R11: interrupt beats call, return and step.
      go(1,1,0,1, 0,8'h00, 0,5'h00, 11'h3AA, 1, "R3_R11");
      // R11: return beats byte write and step; resumes after the interrupted point.
      go(0,0,0,1, 1,8'h77, 0,5'h00, 11'h000, 1, "R11");
      // R11: call beats jump.
      go(0,1,1,0, 0,8'h00, 0,5'h00, 11'h200, 0, "R11");
      // R11: jump beats return, so nothing is popped.
      go(0,0,1,1, 0,8'h00, 0,5'h00, 11'h0F0, 0, "R11");
      go(0,0,0,1, 0,8'h00, 0,5'h00, 11'h000, 0, "R11");
      // R11: byte write beats step.
      go(0,0,0,0, 1,8'h42, 0,5'h00, 11'h000, 1, "R11");

      // Fresh reset, then pops on the empty stack.
      @(negedge clk);
      idle_inputs();
      wait (q_pc.size() == 0);
      do_reset();
      go(0,0,0,1, 0,8'h00, 0,5'h00, 11'h000, 0, "R8");
      go(0,0,0,1, 0,8'h00, 0,5'h00, 11'h000, 0, "R8");
      // R7: nine calls fill the ring and overwrite the oldest entry.
      go(0,0,0,0, 0,8'h00, 1,5'h08, 11'h000, 0, "R10");
      for (int i = 0; i < 9; i++)
         go(0,1,0,0, 0,8'h00, 0,5'h00, 11'(11'h100 + 11'(i * 16)), 0, "R7");
      for (int i = 0; i < 10; i++)
         go(0,0,0,1, 0,8'h00, 0,5'h00, 11'h000, 0, "R7");

      @(negedge clk);
      idle_inputs();
      wait (q_pc.size() == 0);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule